// File: doc/BRIEF.md
# Paged Receive Ring Write Manager

This block places incoming frames into a circular receive buffer made of 256-byte pages. A MAC-side stream delivers each frame as a start strobe, a run of byte strobes, and then either an end strobe or an error strobe. The block drives the write port of an external byte-wide buffer RAM. Each frame is stored behind a 4-byte header in the frame's first page. The header is filled in only once the frame has ended cleanly, because only then are its length and its link to the next free page known.

A host register port holds the ring limits (first page and stop page), the host's boundary page and the hardware's current page. It also holds a write-one-to-clear interrupt status register. The host consumes frames and returns their pages by moving the boundary so that it trails the oldest unread page by one. Before the block takes a fresh page it checks that page against the boundary. A collision abandons the frame and raises an overwrite warning. The block also flags an empty ring continuously. While the 4-byte header is being written, a new start strobe is not accepted.

Top module: `rxring_mgr`

## Requirements
- R1: After reset the start page reads P_START (default 1), the stop page reads P_STOP (default 8), the current page reads P_START, the boundary reads P_STOP-1, the interrupt status reads 0 and ring_empty is 1.
- R2: Frame bytes are written in arrival order, starting at offset 4 of the current page. The RAM byte address is page*256 + offset.
- R3: After the last data byte, the header is written to offsets 0..3 of the frame's first page. The bytes are: status 0x01 (bit 0 marks an intact frame), then the next-page number, then the length low byte, then the length high byte. The length counts every received byte, FCS included, and excludes the header.
- R4: After offset 255 of a page, writing continues at offset 0 of the following page. A following page equal to the stop page is replaced by the start page.
- R5: On a clean end, the current page becomes the page after the last page holding frame data. If the frame filled its last page exactly, that is the page already claimed for the next write. Status bit 0 (frame stored) is set.
- R6: An error strobe during a frame writes no header, leaves the current page unchanged and sets status bit 1 (frame dropped).
- R7: If a page about to be claimed equals the boundary, the frame is abandoned. This covers the first page at start, a page crossing, and the page after the last at end. No header is written, the current page is unchanged and status bit 2 (overwrite warning) is set. Further bytes of that frame are not written.
- R8: ring_empty is 1 exactly when the current page equals boundary+1. A boundary+1 at or above the stop page is first replaced by the start page.
- R9: Writing the status register clears each bit written as 1 and keeps each bit written as 0. A hardware set in the same cycle as a clear of that bit leaves the bit set.
- R10: Host register addresses are 0 start page, 1 stop page, 2 boundary, 3 current page and 4 interrupt status. Addresses 0..3 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Frame byte strobe |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | Clean frame end strobe |
| rx_err | input | 1 | Frame error strobe |
| host_we | input | 1 | Host register write |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| ring_empty | output | 1 | No unread page in the ring |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_addr | output | 16 | Buffer RAM byte address |
| mem_wdata | output | 8 | Buffer RAM write data |

## Verification
The status register can receive a hardware set and a host clear in the same cycle. This happens when the last header byte goes out and the host writes 1 to the frame-stored bit at that moment. The bench places the host write in exactly the cycle that completes the header, and then expects the bit to read back as 1. A scoreboard compares every RAM write, data and header alike, against a page-level model that also predicts the overwrite and wrap cases.

// File: rtl/rxring_pkg.sv
`timescale 1ns/100ps
package rxring_pkg;
   typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_DROP, WR_HDR} wr_state_e;

   localparam int ISR_W    = 3;
   localparam int ISR_DONE = 0;
   localparam int ISR_FAIL = 1;
   localparam int ISR_OVW  = 2;

   localparam logic [2:0] RA_START = 3'd0;
   localparam logic [2:0] RA_STOP  = 3'd1;
   localparam logic [2:0] RA_BND   = 3'd2;
   localparam logic [2:0] RA_CURR  = 3'd3;
   localparam logic [2:0] RA_ISR   = 3'd4;

   localparam int          HDR_BYTES = 4;
   localparam logic [7:0]  HDR_OK    = 8'h01;
endpackage

// File: rtl/rxring_regs.sv
`timescale 1ns/100ps
module rxring_regs
   import rxring_pkg::*;
#(
   parameter int PG_W    = 8,
   parameter int P_START = 1,
   parameter int P_STOP  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [2:0]       host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   input  logic [ISR_W-1:0] isr_set,
   input  logic             curr_upd,
   input  logic [PG_W-1:0]  curr_val,
   output logic [PG_W-1:0]  start_pg,
   output logic [PG_W-1:0]  stop_pg,
   output logic [PG_W-1:0]  bnd_pg,
   output logic [PG_W-1:0]  cur_pg,
   output logic             ring_empty
);
   logic [ISR_W-1:0] isr_q;
   logic [PG_W:0]    bnd_inc;
   logic [PG_W-1:0]  bnd_next;
   logic             isr_wr;

   assign isr_wr = host_we && (host_addr == RA_ISR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_pg <= PG_W'(P_START);
         stop_pg  <= PG_W'(P_STOP);
         bnd_pg   <= PG_W'(P_STOP - 1);
         cur_pg   <= PG_W'(P_START);
      end else begin
         if (host_we && host_addr == RA_START) start_pg <= host_wdata[PG_W-1:0];
         if (host_we && host_addr == RA_STOP)  stop_pg  <= host_wdata[PG_W-1:0];
         if (host_we && host_addr == RA_BND)   bnd_pg   <= host_wdata[PG_W-1:0];
         if (curr_upd)
            cur_pg <= curr_val;
         else if (host_we && host_addr == RA_CURR)
            cur_pg <= host_wdata[PG_W-1:0];
      end
   end

   for (genvar k = 0; k < ISR_W; k++) begin : g_isr
      always_ff @(posedge clk) begin
         if (!rst_n)
            isr_q[k] <= 1'b0;
         else
            isr_q[k] <= isr_set[k] | (isr_q[k] & ~(isr_wr & host_wdata[k]));
      end
      // R9
      isr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         isr_set[k] |=> isr_q[k]);
   end

   assign bnd_inc    = {1'b0, bnd_pg} + 1'b1;
   assign bnd_next   = (bnd_inc >= {1'b0, stop_pg}) ? start_pg : bnd_inc[PG_W-1:0];
   assign ring_empty = (bnd_next == cur_pg);

   always_comb begin
      case (host_addr)
         RA_START: host_rdata = 8'(start_pg);
         RA_STOP:  host_rdata = 8'(stop_pg);
         RA_BND:   host_rdata = 8'(bnd_pg);
         RA_CURR:  host_rdata = 8'(cur_pg);
         RA_ISR:   host_rdata = 8'(isr_q);
         default:  host_rdata = 8'h00;
      endcase
   end

   // R5
   curr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!curr_upd && !(host_we && host_addr == RA_CURR)) |=> $stable(cur_pg));
endmodule

// File: rtl/rxring_wrctl.sv
`timescale 1ns/100ps
module rxring_wrctl
   import rxring_pkg::*;
#(
   parameter int PG_W  = 8,
   parameter int OFF_W = 8,
   localparam int AD_W = PG_W + OFF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_start,
   input  logic            rx_valid,
   input  logic [7:0]      rx_data,
   input  logic            rx_end,
   input  logic            rx_err,
   input  logic [PG_W-1:0] start_pg,
   input  logic [PG_W-1:0] stop_pg,
   input  logic [PG_W-1:0] cur_pg,
   input  logic [PG_W-1:0] bnd_pg,
   output logic            mem_we,
   output logic [AD_W-1:0] mem_addr,
   output logic [7:0]      mem_wdata,
   output logic            ev_done,
   output logic            ev_fail,
   output logic            ev_ovw,
   output logic            curr_upd,
   output logic [PG_W-1:0] curr_val
);
   localparam int CNT_W = 16;

   wr_state_e        st_q, st_n;
   logic [PG_W-1:0]  frm_q, frm_n, pg_q, pg_n, nxt_q, nxt_n, pg_after;
   logic [OFF_W-1:0] off_q, off_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [1:0]       hix_q, hix_n;
   logic             we_n;
   logic [AD_W-1:0]  ad_n;
   logic [7:0]       wd_n;
   logic [PG_W:0]    pg_inc;

   assign pg_inc   = {1'b0, pg_q} + 1'b1;
   assign pg_after = (pg_inc >= {1'b0, stop_pg}) ? start_pg : pg_inc[PG_W-1:0];
   assign curr_val = nxt_q;

   always_comb begin
      st_n = st_q; frm_n = frm_q; pg_n = pg_q; nxt_n = nxt_q;
      off_n = off_q; cnt_n = cnt_q; hix_n = hix_q;
      we_n = 1'b0; ad_n = '0; wd_n = 8'h00;
      ev_done = 1'b0; ev_fail = 1'b0; ev_ovw = 1'b0; curr_upd = 1'b0;
      case (st_q)
         WR_IDLE: if (rx_start) begin
            if (cur_pg == bnd_pg) begin
               ev_ovw = 1'b1;
               st_n   = WR_DROP;
            end else begin
               frm_n = cur_pg;
               pg_n  = cur_pg;
               off_n = OFF_W'(HDR_BYTES);
               cnt_n = '0;
               st_n  = WR_DATA;
            end
         end
         WR_DATA: begin
            if (rx_err) begin
               ev_fail = 1'b1;
               st_n    = WR_IDLE;
            end else if (rx_end) begin
               if (off_q != '0 && pg_after == bnd_pg) begin
                  ev_ovw = 1'b1;
                  st_n   = WR_IDLE;
               end else begin
                  nxt_n = (off_q == '0) ? pg_q : pg_after;
                  hix_n = 2'd0;
                  st_n  = WR_HDR;
               end
            end else if (rx_valid) begin
               we_n  = 1'b1;
               ad_n  = {pg_q, off_q};
               wd_n  = rx_data;
               cnt_n = cnt_q + 1'b1;
               off_n = off_q + 1'b1;
               if (&off_q) begin
                  if (pg_after == bnd_pg) begin
                     ev_ovw = 1'b1;
                     st_n   = WR_DROP;
                  end else begin
                     pg_n = pg_after;
                  end
               end
            end
         end
         WR_DROP: if (rx_end || rx_err) st_n = WR_IDLE;
         WR_HDR: begin
            we_n  = 1'b1;
            ad_n  = {frm_q, OFF_W'(hix_q)};
            hix_n = hix_q + 1'b1;
            case (hix_q)
               2'd0: wd_n = HDR_OK;
               2'd1: wd_n = 8'(nxt_q);
               2'd2: wd_n = cnt_q[7:0];
               default: wd_n = cnt_q[15:8];
            endcase
            if (hix_q == 2'd3) begin
               ev_done  = 1'b1;
               curr_upd = 1'b1;
               st_n     = WR_IDLE;
            end
         end
         default: st_n = WR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= WR_IDLE; frm_q <= '0; pg_q <= '0; nxt_q <= '0;
         off_q <= '0; cnt_q <= '0; hix_q <= '0;
         mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= 8'h00;
      end else begin
         st_q <= st_n; frm_q <= frm_n; pg_q <= pg_n; nxt_q <= nxt_n;
         off_q <= off_n; cnt_q <= cnt_n; hix_q <= hix_n;
         mem_we <= we_n; mem_addr <= ad_n; mem_wdata <= wd_n;
      end
   end

   // R7
   curr_not_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      curr_upd |-> (curr_val != bnd_pg));
   // R4
   ring_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[AD_W-1:OFF_W] >= start_pg && mem_addr[AD_W-1:OFF_W] < stop_pg));
   // R6
   evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_done, ev_fail, ev_ovw}));
endmodule

// File: rtl/rxring_mgr.sv
`timescale 1ns/100ps
module rxring_mgr
   import rxring_pkg::*;
#(
   parameter int PG_W    = 8,
   parameter int OFF_W   = 8,
   parameter int P_START = 1,
   parameter int P_STOP  = 8,
   localparam int AD_W   = PG_W + OFF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_start,
   input  logic            rx_valid,
   input  logic [7:0]      rx_data,
   input  logic            rx_end,
   input  logic            rx_err,
   input  logic            host_we,
   input  logic [2:0]      host_addr,
   input  logic [7:0]      host_wdata,
   output logic [7:0]      host_rdata,
   output logic            ring_empty,
   output logic            mem_we,
   output logic [AD_W-1:0] mem_addr,
   output logic [7:0]      mem_wdata
);
   if (PG_W < 2 || PG_W > 8) begin : g_bad_pg
      $error("page number must fit the one-byte header link");
   end
   if (OFF_W < 3) begin : g_bad_off
      $error("page too small for the frame header");
   end
   if (P_START + 2 > P_STOP || P_STOP > (1 << PG_W)) begin : g_bad_ring
      $error("ring limits out of range");
   end

   logic [PG_W-1:0] start_pg, stop_pg, bnd_pg, cur_pg, curr_val;
   logic            ev_done, ev_fail, ev_ovw, curr_upd;
   logic [ISR_W-1:0] isr_set;

   always_comb begin
      isr_set           = '0;
      isr_set[ISR_DONE] = ev_done;
      isr_set[ISR_FAIL] = ev_fail;
      isr_set[ISR_OVW]  = ev_ovw;
   end

   rxring_regs #(.PG_W(PG_W), .P_START(P_START), .P_STOP(P_STOP)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .isr_set(isr_set),
      .curr_upd(curr_upd), .curr_val(curr_val),
      .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
      .cur_pg(cur_pg), .ring_empty(ring_empty)
   );

   rxring_wrctl #(.PG_W(PG_W), .OFF_W(OFF_W)) u_wrctl (
      .clk(clk), .rst_n(rst_n),
      .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_end(rx_end), .rx_err(rx_err),
      .start_pg(start_pg), .stop_pg(stop_pg), .cur_pg(cur_pg), .bnd_pg(bnd_pg),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ev_done(ev_done), .ev_fail(ev_fail), .ev_ovw(ev_ovw),
      .curr_upd(curr_upd), .curr_val(curr_val)
   );
endmodule

// File: tb/rxring_mgr_tb.sv
`timescale 1ns/100ps
module rxring_mgr_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_start = 0, rx_valid = 0, rx_end = 0, rx_err = 0;
   logic [7:0] rx_data = 0;
   logic host_we = 0;
   logic [2:0] host_addr = 0;
   logic [7:0] host_wdata = 0;
   logic [7:0] host_rdata;
   logic ring_empty, mem_we;
   logic [15:0] mem_addr;
   logic [7:0] mem_wdata;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   int exp_a[$];
   int exp_d[$];
   int m_start = 1, m_stop = 8, m_curr = 1, m_bnd = 7, m_isr = 0;

   always #2.5 clk = ~clk;

   rxring_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_end(rx_end), .rx_err(rx_err),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .ring_empty(ring_empty),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: every RAM write is compared with the scoreboard queue (R2 R3 R4)
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         n_chk++;
         if (exp_a.size() == 0) begin
            n_bad++;
            $display("FAIL R2/R7 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
         end else begin
            int ea, ed;
            ea = exp_a.pop_front();
            ed = exp_d.pop_front();
            if (mem_addr != ea[15:0] || mem_wdata != ed[7:0]) begin
               n_bad++;
               $display("FAIL R2/R3/R4 write actual=%0h:%0h expected=%0h:%0h",
                        mem_addr, mem_wdata, ea, ed);
            end
         end
      end
   end

   task automatic host_wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
      @(negedge clk); host_we = 0;
   endtask

   task automatic host_rd(logic [2:0] a, output int v);
      @(negedge clk); host_addr = a;
      #1 v = host_rdata;
   endtask

   function automatic int nxtp(int p);
      return (p + 1 >= m_stop) ? m_start : p + 1;
   endfunction

   task automatic push(int a, int d);
      exp_a.push_back(a); exp_d.push_back(d);
   endtask

   task automatic send_frame(int n, int seed, bit abort_it, bit clash);
      int pg, off, fp, nx;
      bit ovf;
      pg = m_curr; fp = m_curr; off = 4; ovf = (pg == m_bnd);
      for (int i = 0; i < n; i++) begin
         if (!ovf) begin
            push(pg * 256 + off, (seed + i * 7) & 255);
            off++;
            if (off == 256) begin
               if (nxtp(pg) == m_bnd) ovf = 1;
               else begin pg = nxtp(pg); off = 0; end
            end
         end
      end
      if (ovf) m_isr |= 4;
      else if (abort_it) m_isr |= 2;
      else begin
         nx = (off == 0) ? pg : nxtp(pg);
         if (off != 0 && nx == m_bnd) m_isr |= 4;
         else begin
            push(fp * 256 + 0, 1);
            push(fp * 256 + 1, nx);
            push(fp * 256 + 2, n & 255);
            push(fp * 256 + 3, (n >> 8) & 255);
            m_curr = nx;
            m_isr |= 1;
         end
      end
      @(negedge clk); rx_start = 1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rx_start = 0; rx_valid = 1; rx_data = 8'((seed + i * 7) & 255);
      end
      @(negedge clk); rx_start = 0; rx_valid = 0;
      if (abort_it) rx_err = 1; else rx_end = 1;
      @(negedge clk); rx_end = 0; rx_err = 0;
      if (clash) begin
         repeat (3) @(negedge clk);
         host_we = 1; host_addr = 3'd4; host_wdata = 8'h01;
         @(negedge clk); host_we = 0;
      end
      repeat (8) @(negedge clk);
      check("R2/R3 scoreboard drained", exp_a.size(), 0);
   endtask

   task automatic expect_state(string req);
      int v;
      host_rd(3'd3, v); check({req, " current page"}, v, m_curr);
      host_rd(3'd4, v); check({req, " status"}, v, m_isr);
   endtask

   task automatic clear_all();
      host_wr(3'd4, 8'hFF); m_isr = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 R10 reset values and map
      host_rd(3'd0, v); check("R1 start", v, 1);
      host_rd(3'd1, v); check("R1 stop", v, 8);
      host_rd(3'd2, v); check("R1 boundary", v, 7);
      host_rd(3'd3, v); check("R1 current", v, 1);
      host_rd(3'd4, v); check("R1 status", v, 0);
      check("R1 R8 empty after reset", ring_empty, 1);

      send_frame(60, 3, 0, 0);            // R2 R3 R5
      expect_state("R5 short frame");
      check("R8 not empty", ring_empty, 0);
      host_wr(3'd4, 8'h00);               // R9 zero keeps
      host_rd(3'd4, v); check("R9 zero write keeps", v, 1);
      host_wr(3'd4, 8'h01); m_isr = 0;
      host_rd(3'd4, v); check("R9 one write clears", v, 0);

      send_frame(300, 11, 0, 0);          // R4 page crossing
      expect_state("R4 two-page frame");
      clear_all();
      send_frame(252, 29, 0, 0);          // R5 exact page fill
      expect_state("R5 exact fill");
      clear_all();

      send_frame(600, 5, 0, 0);           // R7 crossing into boundary
      expect_state("R7 overwrite at crossing");
      clear_all();
      host_rd(3'd4, v); check("R9 FF clears warning", v, 0);

      host_wr(3'd2, 8'd4); m_bnd = 4;
      host_rd(3'd2, v); check("R10 boundary readback", v, 4);
      send_frame(800, 77, 0, 0);          // R4 wrap past stop page
      expect_state("R4 ring wrap");
      clear_all();

      send_frame(20, 90, 1, 0);           // R6 errored frame
      expect_state("R6 error frame");
      clear_all();

      host_wr(3'd2, 8'd1); m_bnd = 1;
      check("R8 empty bnd+1==curr", ring_empty, 1);
      host_wr(3'd2, 8'd7); m_bnd = 7;
      check("R8 wrapped bnd+1 not curr", ring_empty, 0);

      host_wr(3'd2, 8'd2); m_bnd = 2;
      send_frame(30, 40, 0, 0);           // R7 first page is boundary
      expect_state("R7 overwrite at start");
      clear_all();
      host_wr(3'd2, 8'd7); m_bnd = 7;

      send_frame(60, 55, 0, 1);           // R9 set and clear collide
      expect_state("R9 set wins over clear");
      clear_all();
      host_rd(3'd4, v); check("R9 cleared afterwards", v, 0);

      host_wr(3'd3, 8'd6);
      host_rd(3'd3, v); check("R10 current readback", v, 6);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule